// File: doc/BRIEF.md
# Spur-Reduced Direct Digital Sine Synthesizer

This core produces a stream of signed digital sine samples whose frequency is set by a tuning word. A phase accumulator advances by the registered tuning word on every enabled clock. Its upper bits, optionally perturbed by a small pseudo-random offset, address a 32-entry sine table. The sample stream is meant to drive a converter. Three measures act against spurious tones. A one-bit toggle is added to the accumulator so that the increment over each pair of cycles is odd. A masked LFSR value can be added to the phase before truncation, which moves overflow points at random. The output is the sum of the current table value and the one before it.

The enable input freezes the whole datapath when low. A fill state machine tracks how many table values have entered the delay-and-add stage. It moves through three named states: EMPTY after reset, PRIMED after the first enabled cycle, and STREAM from the second enabled cycle on. The transitions are EMPTY→PRIMED and PRIMED→STREAM, each on an enabled clock, and any state returns to EMPTY on reset. The accumulator value is brought out as a phase port.

Top module: `spur_dds_core`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets phase to 0, sample to 0 and sample_valid to 0, and reloads the LFSR with 16'hACE1.
- R2: tune_word is captured on every clock edge, reset included, into a holding register. An accumulator update uses the value captured at the previous edge, so a new word first affects phase one edge after it is captured.
- R3: A toggle bit starts at 0 after reset and inverts on each enabled edge. Each enabled edge adds the held word plus the toggle to phase, modulo 2^10, so every two consecutive increments sum to 2·word+1.
- R4: With dithering off, a constant word and en held high, phase returns to 0 for the first time at an even cycle count after exactly 2·2^10 enabled edges.
- R5: The table address is bits [9:5] of (phase + dither) modulo 2^10. With dither_en low the dither is 0.
- R6: With dither_en high, the dither is bits [2:0] of the LFSR state, x^16+x^15+x^13+x^4+1 shifting left with the feedback entering bit 0, which advances on each enabled edge. Over a long run at least one table address then differs from the undithered one.
- R7: Table entry i holds round(127·sin(2πi/32)) as a signed 8-bit value.
- R8: After each enabled edge, sample equals the 9-bit signed sum of the table value addressed at that edge and the table value addressed at the previous enabled edge, which is 0 right after reset. It always lies within ±254.
- R9: sample_valid is 0 after the first enabled edge following reset. It is 1 from the second enabled edge on until the next reset.
- R10: While en is low, phase, sample, sample_valid, the toggle and the LFSR all hold. On resuming, the sequence continues as if the idle cycles had not occurred.
- R11: A reset in mid-stream restarts the phase and sample sequence exactly as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the datapath on this edge |
| dither_en | input | 1 | Add masked LFSR value before truncation |
| tune_word | input | PHASE_W | Frequency tuning word |
| phase | output | PHASE_W | Phase accumulator value |
| sample | output | 9 | Signed sum of the two latest table values |
| sample_valid | output | 1 | Both delay-stage terms are real table values |

## Verification
The hardest condition to reach from the ports is the full-period return of the phase. This needs 2048 uninterrupted enabled cycles with a fixed odd pair increment, and the bench must rule out any earlier return at an even cycle count. A directed run holds the word at 150 from reset for exactly that many cycles. A second hard case is a dither step that actually crosses an address boundary. The bench models the LFSR from its stated polynomial and seed, runs a long dithered stream and counts the cycles where the dithered and undithered addresses differ.

// File: rtl/spur_dds_pkg.sv
package spur_dds_pkg;
    localparam int LUT_ADDR_W = 5;
    localparam int LUT_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_PRIMED = 2'd1,
        ST_STREAM = 2'd2
    } fill_state_t;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PHASE_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] tune_word,
    output logic [PHASE_W-1:0] acc_q,
    output logic               tgl_q
);
    logic [PHASE_W-1:0] word_q;

    // holding register: loads every edge, feeds the adder one edge later
    always_ff @(posedge clk) begin
        word_q <= tune_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            tgl_q <= 1'b0;
        end else if (en) begin
            acc_q <= acc_q + word_q + {{(PHASE_W-1){1'b0}}, tgl_q};
            tgl_q <= ~tgl_q;
        end
    end
endmodule

// File: rtl/dds_dither_lfsr.sv
module dds_dither_lfsr #(
    parameter int              LFSR_W   = 16,
    parameter logic [LFSR_W-1:0] TAPS   = 16'hD008,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
    parameter int              DITHER_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                dither_en,
    output logic [DITHER_W-1:0] dither
);
    logic [LFSR_W-1:0] state_q;
    logic              fb;

    assign fb     = ^(state_q & TAPS);
    assign dither = dither_en ? state_q[DITHER_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (en)
            state_q <= {state_q[LFSR_W-2:0], fb};
    end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom (
    input  logic              [4:0] addr,
    output logic signed       [7:0] value
);
    always_comb begin
        unique case (addr)
            5'd0:  value = 8'sd0;
            5'd1:  value = 8'sd25;
            5'd2:  value = 8'sd49;
            5'd3:  value = 8'sd71;
            5'd4:  value = 8'sd90;
            5'd5:  value = 8'sd106;
            5'd6:  value = 8'sd117;
            5'd7:  value = 8'sd125;
            5'd8:  value = 8'sd127;
            5'd9:  value = 8'sd125;
            5'd10: value = 8'sd117;
            5'd11: value = 8'sd106;
            5'd12: value = 8'sd90;
            5'd13: value = 8'sd71;
            5'd14: value = 8'sd49;
            5'd15: value = 8'sd25;
            5'd16: value = 8'sd0;
            5'd17: value = -8'sd25;
            5'd18: value = -8'sd49;
            5'd19: value = -8'sd71;
            5'd20: value = -8'sd90;
            5'd21: value = -8'sd106;
            5'd22: value = -8'sd117;
            5'd23: value = -8'sd125;
            5'd24: value = -8'sd127;
            5'd25: value = -8'sd125;
            5'd26: value = -8'sd117;
            5'd27: value = -8'sd106;
            5'd28: value = -8'sd90;
            5'd29: value = -8'sd71;
            5'd30: value = -8'sd49;
            5'd31: value = -8'sd25;
            default: value = 8'sd0;
        endcase
    end
endmodule

// File: rtl/dds_delay_add.sv
module dds_delay_add
    import spur_dds_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] cur,
    output logic signed [DATA_W:0]   sample,
    output logic                     valid
);
    fill_state_t state_q, state_d;
    logic signed [DATA_W-1:0] prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (en) state_d = ST_PRIMED;
            ST_PRIMED: if (en) state_d = ST_STREAM;
            ST_STREAM: state_d = ST_STREAM;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // outputs: delay register and widened sum
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            sample <= '0;
        end else if (en) begin
            prev_q <= cur;
            sample <= {cur[DATA_W-1], cur} + {prev_q[DATA_W-1], prev_q};
        end
    end

    assign valid = (state_q == ST_STREAM);
endmodule

// File: rtl/spur_dds_core.sv
module spur_dds_core
    import spur_dds_pkg::*;
#(
    parameter int PHASE_W  = 10,
    parameter int DITHER_W = 3,
    parameter int LFSR_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        dither_en,
    input  logic [PHASE_W-1:0]          tune_word,
    output logic [PHASE_W-1:0]          phase,
    output logic signed [LUT_DATA_W:0]  sample,
    output logic                        sample_valid
);
    localparam int ADDR_W = LUT_ADDR_W;
    localparam int FRAC_W = PHASE_W - ADDR_W;

    logic [PHASE_W-1:0]          acc_q;
    logic                        tgl_q;
    logic [DITHER_W-1:0]         dither;
    logic [PHASE_W-1:0]          dithered;
    logic [ADDR_W-1:0]           lut_addr;
    logic signed [LUT_DATA_W-1:0] lut_val;

    dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk(clk), .rst(rst), .en(en), .tune_word(tune_word),
        .acc_q(acc_q), .tgl_q(tgl_q)
    );

    dds_dither_lfsr #(.LFSR_W(LFSR_W), .DITHER_W(DITHER_W)) u_lfsr (
        .clk(clk), .rst(rst), .en(en), .dither_en(dither_en),
        .dither(dither)
    );

    // dither stays below one address step because DITHER_W < FRAC_W
    assign dithered = acc_q + {{(PHASE_W-DITHER_W){1'b0}}, dither};
    assign lut_addr = dithered[PHASE_W-1 -: ADDR_W];

    dds_sine_rom u_rom (.addr(lut_addr), .value(lut_val));

    dds_delay_add #(.DATA_W(LUT_DATA_W)) u_sum (
        .clk(clk), .rst(rst), .en(en), .cur(lut_val),
        .sample(sample), .valid(sample_valid)
    );

    assign phase = acc_q;

    logic unused_frac;
    assign unused_frac = (FRAC_W > DITHER_W) ? 1'b0 : 1'b1;
endmodule

// File: rtl/spur_dds_core_chk.sv
module spur_dds_core_chk #(
    parameter int PHASE_W = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               dither_en,
    input logic [PHASE_W-1:0] phase,
    input logic [4:0]         lut_addr,
    input logic               tgl,
    input logic signed [8:0]  sample,
    input logic               valid
);
    logic [4:0] addr_step;
    assign addr_step = lut_addr - phase[PHASE_W-1 -: 5];

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (phase == '0 && sample == '0 && !valid));

    a_r3_toggle_alternates: assert property (@(posedge clk) disable iff (rst)
        en |=> (tgl != $past(tgl)));

    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        addr_step <= 5'd1);

    a_r5_undithered_addr: assert property (@(posedge clk) disable iff (rst)
        !dither_en |-> (addr_step == 5'd0));

    a_r8_sum_range: assert property (@(posedge clk) disable iff (rst)
        (sample >= -9'sd254 && sample <= 9'sd254));

    a_r9_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(phase) && $stable(sample) && $stable(valid) && $stable(tgl)));
endmodule

bind spur_dds_core spur_dds_core_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .dither_en(dither_en),
    .phase(phase), .lut_addr(lut_addr), .tgl(tgl_q),
    .sample(sample), .valid(sample_valid)
);

// File: tb/spur_dds_core_tb.sv
module spur_dds_core_tb;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic              dither_en = 1'b0;
    logic [9:0]        tune_word = 10'd150;
    logic [9:0]        phase;
    logic signed [8:0] sample;
    logic              sample_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int lut [32];
    int m_acc, m_tgl, m_frq, m_prev, m_sample, m_vcnt, m_lfsr;
    int diff_addr;

    always #10 clk = ~clk;

    spur_dds_core u_dut (
        .clk(clk), .rst(rst), .en(en), .dither_en(dither_en),
        .tune_word(tune_word), .phase(phase), .sample(sample),
        .sample_valid(sample_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lfsr_next(input int s);
        int fb;
        fb = ((s >> 15) ^ (s >> 14) ^ (s >> 12) ^ (s >> 3)) & 1;
        return ((s << 1) | fb) & 16'hFFFF;
    endfunction

    // one clock: update the model at the edge, compare at the falling edge
    task automatic tick(input string preq);
        int a, a0, cur;
        @(posedge clk);
        if (rst) begin
            m_acc = 0; m_tgl = 0; m_prev = 0; m_sample = 0;
            m_vcnt = 0; m_lfsr = 16'hACE1;
        end else if (en) begin
            a0 = (m_acc >> 5) & 31;
            a  = (((m_acc + (dither_en ? (m_lfsr & 7) : 0)) & 1023) >> 5) & 31;
            if (a != a0) diff_addr++;
            cur = lut[a];
            m_sample = cur + m_prev;
            m_prev = cur;
            m_acc = (m_acc + m_frq + m_tgl) & 1023;
            m_tgl = m_tgl ^ 1;
            m_lfsr = lfsr_next(m_lfsr);
            m_vcnt++;
        end
        m_frq = int'(tune_word);
        @(negedge clk);
        check(int'(phase) == m_acc, preq, int'(phase), m_acc);
        check(int'(sample) == m_sample, "R7/R8 sample", int'(sample), m_sample);
        check(sample_valid == (m_vcnt >= 2), "R9 valid", int'(sample_valid), int'(m_vcnt >= 2));
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0;
        tick("R1 phase");
        tick("R1 phase");
        check(phase == 10'd0, "R1 phase zero", int'(phase), 0);
        check(sample == 9'sd0, "R1 sample zero", int'(sample), 0);
        check(sample_valid == 1'b0, "R1 valid low", int'(sample_valid), 0);
        rst = 1'b0;
    endtask

    task automatic t_fill_and_toggle();
        int p0, p1, p2;
        tune_word = 10'd150; dither_en = 1'b0;
        do_reset();
        en = 1'b1;
        p0 = int'(phase);
        tick("R3 phase");
        check(sample_valid == 1'b0, "R9 not valid after one", int'(sample_valid), 0);
        p1 = int'(phase);
        tick("R3 phase");
        check(sample_valid == 1'b1, "R9 valid after two", int'(sample_valid), 1);
        p2 = int'(phase);
        check(((p1 - p0) & 1023) == 150, "R3 first increment", (p1 - p0) & 1023, 150);
        check(((p2 - p1) & 1023) == 151, "R3 second increment", (p2 - p1) & 1023, 151);
        check(((p2 - p0) & 1023) == 301, "R3 odd pair sum", (p2 - p0) & 1023, 301);
    endtask

    task automatic t_period();
        int early;
        early = 0;
        tune_word = 10'd150; dither_en = 1'b0;
        do_reset();
        en = 1'b1;
        for (int j = 1; j <= 2048; j++) begin
            tick("R4 phase");
            if (j < 2048 && (j % 2) == 0 && phase == 10'd0) early++;
        end
        check(early == 0, "R4 no early return", early, 0);
        check(phase == 10'd0, "R4 return after 2048", int'(phase), 0);
    endtask

    task automatic t_tune_change();
        int pa, pb, pc;
        tune_word = 10'd150; dither_en = 1'b0;
        do_reset();
        en = 1'b1;
        for (int j = 0; j < 6; j++) tick("R2 phase");
        tune_word = 10'd401;
        pa = int'(phase);
        tick("R2 phase");
        pb = int'(phase);
        tick("R2 phase");
        pc = int'(phase);
        check(((pb - pa) & 1023) == 150, "R2 old word used", (pb - pa) & 1023, 150);
        check(((pc - pb) & 1023) == 402, "R2 new word used", (pc - pb) & 1023, 402);
    endtask

    task automatic t_enable_gap();
        int hold_p, hold_s;
        tune_word = 10'd37; dither_en = 1'b1;
        do_reset();
        en = 1'b1;
        for (int j = 0; j < 9; j++) tick("R10 phase");
        hold_p = int'(phase); hold_s = int'(sample);
        en = 1'b0;
        for (int j = 0; j < 5; j++) tick("R10 phase");
        check(int'(phase) == hold_p, "R10 phase held", int'(phase), hold_p);
        check(int'(sample) == hold_s, "R10 sample held", int'(sample), hold_s);
        en = 1'b1;
        for (int j = 0; j < 20; j++) tick("R10 phase");
    endtask

    task automatic t_dither();
        tune_word = 10'd77; dither_en = 1'b1;
        do_reset();
        en = 1'b1;
        diff_addr = 0;
        for (int j = 0; j < 1500; j++) tick("R5 phase");
        check(diff_addr > 0, "R6 dither moves address", diff_addr, 1);
        dither_en = 1'b0;
        for (int j = 0; j < 40; j++) tick("R5 phase");
    endtask

    task automatic t_mid_reset();
        int s1 [4];
        tune_word = 10'd213; dither_en = 1'b0;
        do_reset();
        en = 1'b1;
        for (int j = 0; j < 4; j++) begin tick("R11 phase"); s1[j] = int'(sample); end
        for (int j = 0; j < 30; j++) tick("R11 phase");
        do_reset();
        en = 1'b1;
        for (int j = 0; j < 4; j++) begin
            tick("R11 phase");
            check(int'(sample) == s1[j], "R11 restart sample", int'(sample), s1[j]);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            real x;
            x = 127.0 * $sin(2.0 * 3.14159265358979 * i / 32.0);
            lut[i] = $rtoi(x + ((x >= 0.0) ? 0.5 : -0.5));
        end
        m_acc = 0; m_tgl = 0; m_frq = 150; m_prev = 0; m_sample = 0;
        m_vcnt = 0; m_lfsr = 16'hACE1; diff_addr = 0;
        t_fill_and_toggle();
        t_period();
        t_tune_change();
        t_enable_gap();
        t_dither();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule